// File: doc/BRIEF.md
# Serial-Bus Slave Configuration Space Responder

This block answers 32-bit word accesses that a serial-bus slave receives over its 2 MiB address space. Each access goes to one of three windows. The low window is a read-only configuration table: a chip identifier, then a chain of engine descriptor words. The middle window is the slave's own control registers, stubbed here. The upper window is a local bus of engines. The local bus carries a configurable number of single-register scratchpad engines, each in its own 1 KiB slot.

The descriptor chain is generated from the attached engine count. It lists a peek engine, a bus-bridge engine and then one descriptor per scratchpad engine, and it ends with a zero word. Reads past that zero word return a break magic value. A master that writes the same magic value to the table's first two words cold-resets every local-bus engine.

Accesses use a single-cycle request and a registered acknowledge. Read data is valid with the acknowledge, one cycle after the request. The data word is carried most-significant byte first, so bit 31 of the bus is the first byte on the wire.

Top module: `cfg_space_responder`

## Requirements
- R1: While reset is asserted, and on the first accesses after it, `ack` and `rdata` are 0 and every scratchpad register reads 0.
- R2: A request sampled at a clock edge produces `ack`=1 after that edge, for one cycle per request. With no request, `ack` is 0 and `rdata` is 0.
- R3: A read of byte address 0x000 returns the chip identifier 0xC0022D15.
- R4: The descriptor word format is: bit 31 = next-entry-valid, bits 23:16 = slot count, bits 15:12 = version, bits 7:4 = engine type, bits 3:0 = check nibble. Type codes are 2 for peek, 3 for bus bridge and 6 for scratchpad. Address 0x004 reads 0x8001102C (peek) and address 0x008 reads 0x8001503A (bridge).
- R5: Starting at 0x00C, each word holds the scratchpad descriptor 0x80011067, one per attached engine. The word after the last engine reads 0.
- R6: Any read in the table window (0x000–0x3FF) beyond the zero word returns 0xC0DE0000.
- R7: The table is read-only. A write changes no table word. A write other than exactly 0xC0DE0000 to 0x000 or 0x004 leaves the engines unchanged.
- R8: A write of 0xC0DE0000 to 0x000 or 0x004 clears every scratchpad register. The clear takes effect at the clock edge after the write is accepted, so a read issued back-to-back with that write still returns the old value.
- R9: Scratchpad engine k has one 32-bit read/write register at byte address 0xC00 + k*0x400.
- R10: Every other word in a scratchpad's 0x400 window reads 0, and writes to it have no effect.
- R11: An access with address bits 1:0 not 00 is acknowledged normally, returns 0 and has no side effect, including magic writes and engine writes.
- R12: Accesses to 0x400–0x7FF, to the slave-register window 0x800–0xBFF, and to local-bus slots with no engine are acknowledged, return 0 and have no side effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (21) | Byte address within the slave space |
| wdata | input | 32 | Write data, bit 31 = first byte on the wire |
| rdata | output | 32 | Read data, valid with ack |
| ack | output | 1 | Access complete, one cycle after req |

## Verification
The bench builds the block with three scratchpad engines instead of the default two. With three engines the descriptor chain is long enough that the zero terminator lands at 0x018 and the first break-magic word at 0x01C. It also puts an engine at a slot (0x1400) that is neither the first nor a power-of-two count, and leaves the fourth slot at 0x1800 empty, so the empty-slot path of the local-bus decoder is exercised. With all three registers holding distinct values, the bench can show that one break write clears every engine at once and that a back-to-back read still sees the old value.

// File: rtl/cfgsr_pkg.sv
package cfgsr_pkg;

    localparam int          DATA_W      = 32;
    localparam logic [31:0] CHIP_ID     = 32'hC002_2D15;
    localparam logic [31:0] BREAK_MAGIC = 32'hC0DE_0000;

    // Window base addresses (byte)
    localparam int CFG_END   = 32'h400;
    localparam int SLV_BASE  = 32'h800;
    localparam int LBUS_BASE = 32'hC00;
    localparam int SLOT_LOG2 = 10;          // 0x400 bytes per engine slot

    // Engine type codes
    localparam logic [3:0] ETYPE_PEEK    = 4'h2;
    localparam logic [3:0] ETYPE_BRIDGE  = 4'h3;
    localparam logic [3:0] ETYPE_SCRATCH = 4'h6;

    typedef enum logic [1:0] {
        WIN_CFG  = 2'd0,
        WIN_SLV  = 2'd1,
        WIN_LBUS = 2'd2,
        WIN_NONE = 2'd3
    } win_e;

    // Descriptor: [31] next valid, [23:16] slots, [15:12] version,
    // [7:4] type, [3:0] check nibble
    function automatic logic [31:0] mk_desc(input logic [7:0] slots,
                                            input logic [3:0] ver,
                                            input logic [3:0] etype,
                                            input logic [3:0] chk);
        return {1'b1, 7'b0, slots, ver, 4'b0, etype, chk};
    endfunction

    localparam logic [31:0] DESC_PEEK    = mk_desc(8'd1, 4'd1, ETYPE_PEEK,    4'hC);
    localparam logic [31:0] DESC_BRIDGE  = mk_desc(8'd1, 4'd5, ETYPE_BRIDGE,  4'hA);
    localparam logic [31:0] DESC_SCRATCH = mk_desc(8'd1, 4'd1, ETYPE_SCRATCH, 4'h7);

endpackage

// File: rtl/cfgsr_decode.sv
module cfgsr_decode
    import cfgsr_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int N_ENG  = 2,
    parameter int ENG_W  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic              aligned,
    output logic [7:0]        cfg_idx,
    output logic              eng_hit,
    output logic [ENG_W-1:0]  eng_sel,
    output logic              eng_off0
);
    localparam int BLK_W = ADDR_W - SLOT_LOG2;
    localparam logic [ADDR_W-1:0] A_CFG_END = ADDR_W'(CFG_END);
    localparam logic [ADDR_W-1:0] A_SLV     = ADDR_W'(SLV_BASE);
    localparam logic [ADDR_W-1:0] A_LBUS    = ADDR_W'(LBUS_BASE);
    localparam logic [BLK_W-1:0]  BLK_LIM   = BLK_W'(N_ENG);

    logic [ADDR_W-1:0] loc;
    logic [BLK_W-1:0]  blk;

    always_comb begin
        if (addr < A_CFG_END)      win = WIN_CFG;
        else if (addr < A_SLV)     win = WIN_NONE;
        else if (addr < A_LBUS)    win = WIN_SLV;
        else                       win = WIN_LBUS;
    end

    assign aligned  = (addr[1:0] == 2'b00);
    assign cfg_idx  = addr[SLOT_LOG2-1:2];
    assign loc      = addr - A_LBUS;
    assign blk      = loc[ADDR_W-1:SLOT_LOG2];
    assign eng_hit  = (win == WIN_LBUS) && (blk < BLK_LIM);
    assign eng_sel  = blk[ENG_W-1:0];
    assign eng_off0 = (loc[SLOT_LOG2-1:0] == '0);

endmodule

// File: rtl/cfgsr_table.sv
module cfgsr_table
    import cfgsr_pkg::*;
#(
    parameter int N_ENG = 2   // must stay below 252 to fit the 0x400 window
) (
    input  logic [7:0]        idx,
    output logic [DATA_W-1:0] word
);
    localparam logic [7:0] FIRST_ENG = 8'd3;
    localparam logic [7:0] TERM_IDX  = 8'(3 + N_ENG);

    always_comb begin
        if (idx == 8'd0)             word = CHIP_ID;
        else if (idx == 8'd1)        word = DESC_PEEK;
        else if (idx == 8'd2)        word = DESC_BRIDGE;
        else if (idx >= FIRST_ENG && idx < TERM_IDX)
                                     word = DESC_SCRATCH;
        else if (idx == TERM_IDX)    word = '0;
        else                         word = BREAK_MAGIC;
    end

endmodule

// File: rtl/cfgsr_scratch.sv
module cfgsr_scratch
    import cfgsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (clr)        reg_d = '0;
        else if (wr_en) reg_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign q = reg_q;

endmodule

// File: rtl/cfg_space_responder.sv
module cfg_space_responder
    import cfgsr_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int N_ENG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ack
);
    localparam int ENG_W = (N_ENG > 1) ? $clog2(N_ENG) : 1;

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic              brk;
    } rsp_t;

    rsp_t state_d, state_q;

    win_e             win;
    logic             aligned;
    logic [7:0]       cfg_idx;
    logic             eng_hit;
    logic [ENG_W-1:0] eng_sel;
    logic             eng_off0;
    logic [DATA_W-1:0] tbl_word;
    logic [DATA_W-1:0] eng_q [N_ENG];
    logic [N_ENG-1:0]  eng_wr;
    logic [DATA_W-1:0] eng_rd;
    logic              brk_pulse;
    logic              eng_acc;

    cfgsr_decode #(.ADDR_W(ADDR_W), .N_ENG(N_ENG), .ENG_W(ENG_W)) u_dec (
        .addr     (addr),
        .win      (win),
        .aligned  (aligned),
        .cfg_idx  (cfg_idx),
        .eng_hit  (eng_hit),
        .eng_sel  (eng_sel),
        .eng_off0 (eng_off0)
    );

    cfgsr_table #(.N_ENG(N_ENG)) u_tbl (
        .idx  (cfg_idx),
        .word (tbl_word)
    );

    // A register access lands only on an aligned word at slot offset 0
    assign eng_acc   = req && aligned && eng_hit && eng_off0;
    assign brk_pulse = state_q.brk;

    for (genvar k = 0; k < N_ENG; k++) begin : g_eng
        assign eng_wr[k] = eng_acc && we && (eng_sel == ENG_W'(k));
        cfgsr_scratch u_scr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (brk_pulse),
            .wr_en (eng_wr[k]),
            .wdata (wdata),
            .q     (eng_q[k])
        );
    end

    always_comb begin
        eng_rd = '0;
        for (int k = 0; k < N_ENG; k++) begin
            if (eng_sel == ENG_W'(k)) eng_rd = eng_q[k];
        end
    end

    always_comb begin
        state_d       = '0;
        state_d.ack   = req;
        if (req && !we && aligned) begin
            unique case (win)
                WIN_CFG:  state_d.rdata = tbl_word;
                WIN_LBUS: state_d.rdata = (eng_hit && eng_off0) ? eng_rd : '0;
                default:  state_d.rdata = '0;
            endcase
        end
        state_d.brk = req && we && aligned && (win == WIN_CFG) &&
                      (cfg_idx <= 8'd1) && (wdata == BREAK_MAGIC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ack   = state_q.ack;
    assign rdata = state_q.rdata;

endmodule

// File: rtl/cfgsr_checker.sv
module cfgsr_checker
    import cfgsr_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              ack,
    input logic              brk_pulse
);
    logic magic_wr;
    assign magic_wr = req && we && (wdata == BREAK_MAGIC) &&
                      (addr == ADDR_W'(0) || addr == ADDR_W'(4));

    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);

    assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !ack);

    assert_idle_rdata_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> (rdata == 32'h0));

    assert_chip_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr == ADDR_W'(0)) |=> (rdata == CHIP_ID));

    assert_unaligned_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr[1:0] != 2'b00) |=> (rdata == 32'h0));

    assert_magic_pulses_R8: assert property (@(posedge clk) disable iff (!rst_n)
        magic_wr |=> brk_pulse);

    assert_pulse_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(magic_wr));

    assert_hole_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && addr >= ADDR_W'(32'h400) && addr < ADDR_W'(32'hC00))
        |=> (rdata == 32'h0));

endmodule

bind cfg_space_responder cfgsr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .ack       (ack),
    .brk_pulse (brk_pulse)
);

// File: tb/tb_cfg_space_responder.sv
module tb_cfg_space_responder;

    localparam int ADDR_W = 21;
    localparam int N_ENG  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              ack;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cfg_space_responder #(.ADDR_W(ADDR_W), .N_ENG(N_ENG)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .ack(ack)
    );

    typedef struct packed {
        logic        w;
        logic [20:0] a;
        logic [31:0] d;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 21'h000000, 32'h0,         32'hC0022D15, 8'd3},  // R3
        '{1'b0, 21'h000004, 32'h0,         32'h8001102C, 8'd4},  // R4 peek
        '{1'b0, 21'h000008, 32'h0,         32'h8001503A, 8'd4},  // R4 bridge
        '{1'b0, 21'h00000C, 32'h0,         32'h80011067, 8'd5},  // R5
        '{1'b0, 21'h000010, 32'h0,         32'h80011067, 8'd5},
        '{1'b0, 21'h000014, 32'h0,         32'h80011067, 8'd5},
        '{1'b0, 21'h000018, 32'h0,         32'h00000000, 8'd5},  // terminator
        '{1'b0, 21'h00001C, 32'h0,         32'hC0DE0000, 8'd6},  // R6
        '{1'b0, 21'h0003FC, 32'h0,         32'hC0DE0000, 8'd6},
        '{1'b1, 21'h000000, 32'h12345678,  32'h0,        8'd7},  // R7
        '{1'b0, 21'h000000, 32'h0,         32'hC0022D15, 8'd7},
        '{1'b1, 21'h000C00, 32'hA5A55A5A,  32'h0,        8'd9},  // R9
        '{1'b0, 21'h000C00, 32'h0,         32'hA5A55A5A, 8'd9},
        '{1'b1, 21'h001000, 32'h11112222,  32'h0,        8'd9},
        '{1'b0, 21'h001000, 32'h0,         32'h11112222, 8'd9},
        '{1'b1, 21'h001400, 32'h33334444,  32'h0,        8'd9},
        '{1'b0, 21'h001400, 32'h0,         32'h33334444, 8'd9},
        '{1'b1, 21'h000C04, 32'hFFFFFFFF,  32'h0,        8'd10}, // R10
        '{1'b0, 21'h000C04, 32'h0,         32'h0,        8'd10},
        '{1'b0, 21'h000C00, 32'h0,         32'hA5A55A5A, 8'd10},
        '{1'b1, 21'h000C01, 32'h0,         32'h0,        8'd11}, // R11
        '{1'b0, 21'h000C00, 32'h0,         32'hA5A55A5A, 8'd11},
        '{1'b0, 21'h000002, 32'h0,         32'h0,        8'd11},
        '{1'b1, 21'h000001, 32'hC0DE0000,  32'h0,        8'd11},
        '{1'b0, 21'h001000, 32'h0,         32'h11112222, 8'd11},
        '{1'b0, 21'h000400, 32'h0,         32'h0,        8'd12}, // R12
        '{1'b0, 21'h000800, 32'h0,         32'h0,        8'd12},
        '{1'b1, 21'h001800, 32'hDEADBEEF,  32'h0,        8'd12},
        '{1'b0, 21'h001800, 32'h0,         32'h0,        8'd12},
        '{1'b1, 21'h000008, 32'hC0DE0000,  32'h0,        8'd7},  // R7 magic elsewhere
        '{1'b1, 21'h000000, 32'hC0DE0001,  32'h0,        8'd7},
        '{1'b0, 21'h001400, 32'h0,         32'h33334444, 8'd7}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at a later negedge with ack/rdata sampled.
    task automatic access(input logic w, input logic [20:0] a, input logic [31:0] d,
                          output logic got_ack, output logic [31:0] got_rd);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        got_ack = ack;
        got_rd  = rdata;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        logic        ga;
        logic [31:0] gr;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 ack in reset", {31'b0, ack}, 32'h0);
        check("R1 rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;
        idle();
        access(1'b0, 21'h000C00, 32'h0, ga, gr); check("R1 engine0 after reset", gr, 32'h0);
        access(1'b0, 21'h001000, 32'h0, ga, gr); check("R1 engine1 after reset", gr, 32'h0);
        access(1'b0, 21'h001400, 32'h0, ga, gr); check("R1 engine2 after reset", gr, 32'h0);

        // R2: one-cycle ack, low when idle
        check("R2 ack with response", {31'b0, ga}, 32'h1);
        idle();
        check("R2 ack idle", {31'b0, ack}, 32'h0);
        check("R2 rdata idle", rdata, 32'h0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].w, VECS[i].a, VECS[i].d, ga, gr);
            check($sformatf("R2 ack vec%0d", i), {31'b0, ga}, 32'h1);
            check($sformatf("R%0d vec%0d addr %h", VECS[i].rq, i, VECS[i].a), gr, VECS[i].exp);
            idle();
        end

        // R8: break via 0x004, back-to-back read still old, then cleared
        access(1'b1, 21'h000004, 32'hC0DE0000, ga, gr);
        access(1'b0, 21'h000C00, 32'h0, ga, gr);
        check("R8 back-to-back read sees old value", gr, 32'hA5A55A5A);
        idle();
        access(1'b0, 21'h000C00, 32'h0, ga, gr); check("R8 engine0 cleared", gr, 32'h0);
        access(1'b0, 21'h001000, 32'h0, ga, gr); check("R8 engine1 cleared", gr, 32'h0);
        access(1'b0, 21'h001400, 32'h0, ga, gr); check("R8 engine2 cleared", gr, 32'h0);

        // R8: break via 0x000
        access(1'b1, 21'h001000, 32'h0BADF00D, ga, gr);
        idle();
        access(1'b0, 21'h001000, 32'h0, ga, gr); check("R9 engine1 refilled", gr, 32'h0BADF00D);
        access(1'b1, 21'h000000, 32'hC0DE0000, ga, gr);
        idle();
        access(1'b0, 21'h001000, 32'h0, ga, gr); check("R8 break at 0x000 clears", gr, 32'h0);
        access(1'b0, 21'h000000, 32'h0, ga, gr); check("R7 table intact after break", gr, 32'hC0022D15);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule